// File: doc/BRIEF.md
# Tiled Surface Replicating Writer

This block moves a rectangle of 32-bit words between a packed word stream and a pitched surface held in a word-addressed memory. In the write direction, words arrive on a valid/ready input stream and are stored into the surface. In the read direction, surface words are fetched and sent out on a valid/ready output stream. The surface may be untiled, in which case the transfer is one contiguous run. It may also be a tile region addressed by a start offset and a tile pitch. A tile may use a replicating layout, where each logical word fills a 2x2 block of surface words.

A transfer starts with a one-cycle `start` pulse. That pulse samples the direction, layout mode, start offset, tile pitch, stream row length and rectangle size. All offsets and pitches count 32-bit words. The start offset splits into a start row (offset divided by tile pitch) and a start column (offset modulo tile pitch). The surface word at row r and column c therefore sits at `offset + r*tile_pitch + c`, and the block uses this sum directly with no divider.

Back-pressure rules:
- Input stream: a word is consumed only once its last surface write has been accepted. The source must hold `in_valid` and `in_data` until `in_ready`.
- Output stream: a word stays on `out_data` with `out_valid` high until `out_ready`.
- Memory port: one access per cycle. A request completes when `mem_valid` and `mem_ready` are both high. Read data on `mem_rdata` is valid in that same cycle.
- A read request is offered only when the output holding register is empty or is being drained.

Top module: `tsr_xfer`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `mem_valid`, `in_ready` and `out_valid` are all low.
- R2: In mode 0 (untiled), a write stores `height*src_pitch` stream words at consecutive addresses starting at `offset`, in stream order.
- R3: In mode 1 (tiled, plain), a write stores stream word number `y*src_pitch+x`, for x below `src_pitch`, at `offset + y*tile_pitch + x`. Words are taken in row-major order.
- R4: Mode 2 (tiled, two-by-one) behaves exactly as mode 1 in both directions.
- R5: In mode 3 (tiled, 2x2 replicated), a write takes `width*height` stream words in row-major order. Word (x,y) is stored at `offset + (2y+dy)*tile_pitch + 2x+dx` for all dy,dx in {0,1}, which makes exactly `4*width*height` writes.
- R6: In mode 3, a read issues exactly `width*height` reads. Output word (x,y), in row-major order, is the surface word at `offset + 2y*tile_pitch + 2x`.
- R7: In modes 0 to 2, a read returns, in row-major order, the words at the same addresses a write would use (R2, R3).
- R8: A `start` with a mode of 4 to 7 raises `err` for exactly the cycle after `start`, makes no memory access and raises no `done`.
- R9: A `start` with zero `height`, or with zero row length (`width` in mode 3, `src_pitch` in modes 0 to 2), raises `done` in the cycle after `start` and makes no memory access.
- R10: `busy` is high from the cycle after an accepted `start` until the final access is accepted. `done` is high for the one cycle after that acceptance.
- R11: Under back-pressure on any side, no word is lost, duplicated or reordered. A stalled read request keeps its address, and a stalled output word keeps its value.
- R12: A `start` pulse while `busy` is high is ignored, together with the parameters presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer with the presented parameters |
| dir_rd | input | 1 | 1 = surface to stream, 0 = stream to surface |
| mode | input | 3 | Layout: 0 untiled, 1 tiled plain, 2 tiled two-by-one, 3 tiled 2x2, others invalid |
| offset | input | AW | Start word offset of the region |
| tile_pitch | input | AW | Surface row pitch in words |
| src_pitch | input | LW | Stream words per row in modes 0 to 2 |
| width | input | LW | Logical words per row in mode 3 |
| height | input | LW | Number of logical rows |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle unsupported-mode pulse |
| in_valid | input | 1 | Input stream word valid |
| in_ready | output | 1 | Input stream word consumed |
| in_data | input | DW | Input stream word |
| out_valid | output | 1 | Output stream word valid |
| out_ready | input | 1 | Output stream sink ready |
| out_data | output | DW | Output stream word |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data, valid in the accepting cycle |

## Verification
Random transfers vary the mode, direction, offset, tile pitch, row length and rectangle size. Random ready signals on the memory and output sides are mixed in. A tile pitch smaller than twice the width makes 2x2 blocks overlap, so the final memory image depends on the write order and not only on the set of addresses written. Write checks compare the whole memory image, which catches stray or missing replicas. Read checks compare the ordered output stream, which separates the top-left pick of mode 3 from the other three copies. Directed cases cover mode 1 against mode 2, zero height, zero width, zero row length, invalid modes, and a second `start` during a transfer.

// File: rtl/tsr_pkg.sv
package tsr_pkg;
  localparam logic [2:0] MODE_LINEAR    = 3'd0;
  localparam logic [2:0] MODE_TILED     = 3'd1;
  localparam logic [2:0] MODE_TILED_2X1 = 3'd2;
  localparam logic [2:0] MODE_QUAD      = 3'd3;

  typedef enum logic {ST_IDLE, ST_RUN} tsr_state_e;
endpackage

// File: rtl/tsr_cfg_decode.sv
module tsr_cfg_decode import tsr_pkg::*; #(
  parameter int AW = 20,
  parameter int LW = 12
) (
  input  logic [2:0]    mode,
  input  logic          rd,
  input  logic [AW-1:0] tile_pitch,
  input  logic [LW-1:0] src_pitch,
  input  logic [LW-1:0] width,
  input  logic [LW-1:0] height,
  output logic          ok,
  output logic          empty,
  output logic          replicate,
  output logic          pair_cols,
  output logic [LW-1:0] row_len,
  output logic [AW-1:0] row_stride
);
  logic linear;
  logic quad;

  always_comb begin
    ok     = 1'b1;
    linear = 1'b0;
    quad   = 1'b0;
    case (mode)
      MODE_LINEAR:                linear = 1'b1;
      MODE_TILED, MODE_TILED_2X1: ;
      MODE_QUAD:                  quad = 1'b1;
      default:                    ok = 1'b0;
    endcase
    row_len = quad ? width : src_pitch;
    if (linear)    row_stride = AW'(src_pitch);
    else if (quad) row_stride = tile_pitch << 1;
    else           row_stride = tile_pitch;
    empty     = (height == '0) || (row_len == '0);
    replicate = quad & ~rd;
    pair_cols = quad;
  end
endmodule

// File: rtl/tsr_walker.sv
module tsr_walker #(
  parameter int AW = 20,
  parameter int LW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] ld_base,
  input  logic [AW-1:0] ld_stride,
  input  logic [AW-1:0] ld_pitch,
  input  logic [LW-1:0] ld_len,
  input  logic [LW-1:0] ld_rows,
  input  logic          ld_pair,
  input  logic          ld_rep,
  output logic [AW-1:0] addr,
  output logic          sub_last,
  output logic          last
);
  logic [AW-1:0] row_q, col_q, stride_q, pitch_q;
  logic [LW-1:0] len_q, rows_q, x_q, y_q;
  logic [1:0]    sub_q;
  logic          pair_q, rep_q;
  logic          row_end;

  assign sub_last = !rep_q || (sub_q == 2'd3);
  assign row_end  = (x_q == len_q - 1'b1);
  assign last     = sub_last && row_end && (y_q == rows_q - 1'b1);
  assign addr     = row_q + col_q + (sub_q[1] ? pitch_q : '0) + AW'(sub_q[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q <= '0; col_q <= '0; stride_q <= '0; pitch_q <= '0;
      len_q <= '0; rows_q <= '0; x_q <= '0; y_q <= '0;
      sub_q <= '0; pair_q <= 1'b0; rep_q <= 1'b0;
    end else if (load) begin
      row_q    <= ld_base;
      col_q    <= '0;
      stride_q <= ld_stride;
      pitch_q  <= ld_pitch;
      len_q    <= ld_len;
      rows_q   <= ld_rows;
      x_q      <= '0;
      y_q      <= '0;
      sub_q    <= '0;
      pair_q   <= ld_pair;
      rep_q    <= ld_rep;
    end else if (step) begin
      if (!sub_last) begin
        sub_q <= sub_q + 2'd1;
      end else begin
        sub_q <= '0;
        if (row_end) begin
          x_q   <= '0;
          col_q <= '0;
          y_q   <= y_q + 1'b1;
          row_q <= row_q + stride_q;
        end else begin
          x_q   <= x_q + 1'b1;
          col_q <= col_q + (pair_q ? AW'(2) : AW'(1));
        end
      end
    end
  end
endmodule

// File: rtl/tsr_rd_hold.sv
module tsr_rd_hold #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] cap_data,
  output logic          free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          valid_q;
  logic [DW-1:0] data_q;

  assign free      = !valid_q || out_ready;
  assign out_valid = valid_q;
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else if (cap) begin
      valid_q <= 1'b1;
      data_q  <= cap_data;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tsr_xfer.sv
module tsr_xfer import tsr_pkg::*; #(
  parameter int AW = 20,
  parameter int LW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          dir_rd,
  input  logic [2:0]    mode,
  input  logic [AW-1:0] offset,
  input  logic [AW-1:0] tile_pitch,
  input  logic [LW-1:0] src_pitch,
  input  logic [LW-1:0] width,
  input  logic [LW-1:0] height,
  output logic          busy,
  output logic          done,
  output logic          err,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);
  tsr_state_e    state_q;
  logic          rd_q, done_q, err_q;
  logic          cfg_ok, cfg_empty, cfg_rep, cfg_pair;
  logic [LW-1:0] cfg_len;
  logic [AW-1:0] cfg_stride;
  logic          run, launch, go, acc;
  logic          sub_last, last;
  logic          hold_free;

  tsr_cfg_decode #(.AW(AW), .LW(LW)) u_dec (
    .mode(mode), .rd(dir_rd), .tile_pitch(tile_pitch), .src_pitch(src_pitch),
    .width(width), .height(height), .ok(cfg_ok), .empty(cfg_empty),
    .replicate(cfg_rep), .pair_cols(cfg_pair), .row_len(cfg_len), .row_stride(cfg_stride)
  );

  assign run    = (state_q == ST_RUN);
  assign launch = start && (state_q == ST_IDLE);
  assign go     = launch && cfg_ok && !cfg_empty;

  tsr_walker #(.AW(AW), .LW(LW)) u_walk (
    .clk(clk), .rst_n(rst_n), .load(go), .step(acc),
    .ld_base(offset), .ld_stride(cfg_stride), .ld_pitch(tile_pitch),
    .ld_len(cfg_len), .ld_rows(height), .ld_pair(cfg_pair), .ld_rep(cfg_rep),
    .addr(mem_addr), .sub_last(sub_last), .last(last)
  );

  tsr_rd_hold #(.DW(DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .cap(acc && rd_q), .cap_data(mem_rdata),
    .free(hold_free), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always_comb begin
    mem_valid = run && (rd_q ? hold_free : in_valid);
    mem_we    = run && !rd_q;
    mem_wdata = in_data;
    in_ready  = run && !rd_q && mem_ready && sub_last;
    acc       = mem_valid && mem_ready;
  end

  assign busy = run;
  assign done = done_q;
  assign err  = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rd_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (launch) begin
        if (!cfg_ok) begin
          err_q <= 1'b1;
        end else if (cfg_empty) begin
          done_q <= 1'b1;
        end else begin
          state_q <= ST_RUN;
          rd_q    <= dir_rd;
        end
      end else if (run && acc && last) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsr_xfer_chk.sv
module tsr_xfer_chk #(
  parameter int AW = 20,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr
);
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!done && !busy && !mem_valid)); // R8
  AST_ACC_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy); // R10
  AST_RD_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready && !mem_we) |=> (mem_valid && $stable(mem_addr))); // R11
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R11
  AST_IN_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> (mem_valid && mem_ready && mem_we)); // R11
endmodule

bind tsr_xfer tsr_xfer_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr)
);

// File: tb/tsr_xfer_tb.sv
`timescale 1ns/1ps
module tsr_xfer_tb;
  localparam int AW = 20;
  localparam int LW = 12;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, dir_rd = 1'b0;
  logic [2:0] mode = '0;
  logic [AW-1:0] offset = '0, tile_pitch = '0;
  logic [LW-1:0] src_pitch = '0, width = '0, height = '0;
  logic busy, done, err;
  logic in_valid = 1'b0, in_ready;
  logic [DW-1:0] in_data = '0;
  logic out_valid, out_ready = 1'b0;
  logic [DW-1:0] out_data;
  logic mem_valid, mem_ready = 1'b0, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;

  logic [DW-1:0] bmem [0:4095];
  logic [DW-1:0] emem [0:4095];
  logic [DW-1:0] src  [0:255];
  logic [DW-1:0] got  [0:255];

  int total = 0, bad = 0;
  int nacc, ngot, sidx, done_it, err_it, last_acc;
  bit busy1;

  assign mem_rdata = bmem[mem_addr[11:0]];

  always #4 clk = ~clk;

  tsr_xfer #(.AW(AW), .LW(LW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_rd(dir_rd), .mode(mode),
    .offset(offset), .tile_pitch(tile_pitch), .src_pitch(src_pitch),
    .width(width), .height(height), .busy(busy), .done(done), .err(err),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic fill(input int salt);
    for (int i = 0; i < 4096; i++) begin
      bmem[i] = (i * 32'h9E3779B1) ^ salt;
      emem[i] = bmem[i];
    end
    for (int i = 0; i < 256; i++) src[i] = $urandom;
  endtask

  function automatic int stream_cnt(input int md, input int sp, input int w, input int h);
    return (md == 3) ? w * h : h * sp;
  endfunction

  task automatic run(input bit rd, input int md, input int off, input int tp,
                     input int sp, input int w, input int h, input bit poke);
    int it;
    bit fin;
    int tot;
    tot = stream_cnt(md, sp, w, h);
    nacc = 0; ngot = 0; sidx = 0; done_it = -1; err_it = -1; last_acc = -1; busy1 = 0;
    @(negedge clk);
    start = 1'b1; dir_rd = rd; mode = md[2:0]; offset = off[AW-1:0];
    tile_pitch = tp[AW-1:0]; src_pitch = sp[LW-1:0]; width = w[LW-1:0]; height = h[LW-1:0];
    @(posedge clk);
    it = 1; fin = 0;
    while (!fin && it < 6000) begin
      @(negedge clk);
      start = poke && (it == 3);
      if (poke && it == 3) begin
        dir_rd = ~rd; mode = 3'd3; offset = offset + 20'd5;
      end
      mem_ready = ($urandom_range(0, 3) != 0);
      out_ready = ($urandom_range(0, 3) != 0);
      in_valid  = !rd && (sidx < tot);
      in_data   = src[sidx & 255];
      #1;
      if (it == 1) busy1 = busy;
      if (done && done_it < 0) done_it = it;
      if (err && err_it < 0) err_it = it;
      if (mem_valid && mem_ready) begin
        nacc++;
        last_acc = it;
        if (mem_we) bmem[mem_addr[11:0]] = mem_wdata;
      end
      if (in_valid && in_ready) sidx++;
      if (out_valid && out_ready) begin
        if (ngot < 256) got[ngot] = out_data;
        ngot++;
      end
      if ((done_it >= 0 || err_it >= 0) && !out_valid && !busy) fin = 1;
      @(posedge clk);
      it++;
    end
    @(negedge clk);
    start = 1'b0; in_valid = 1'b0; mem_ready = 1'b0; out_ready = 1'b0;
  endtask

  task automatic verify(input bit rd, input int md, input int off, input int tp,
                        input int sp, input int w, input int h, input string tag);
    int exp_acc, k, nbad, first;
    exp_acc = (md == 3) ? (rd ? w * h : 4 * w * h) : h * sp;
    chk(err_it < 0, "R8", {tag, " no err on valid mode"}, err_it, -1);
    chk(nacc == exp_acc, tag, "access count", nacc, exp_acc);
    chk(busy1 && done_it == last_acc + 1, "R10", {tag, " done one cycle after last access"},
        done_it, last_acc + 1);
    if (!rd) begin
      if (md == 0) begin
        for (int i = 0; i < h * sp; i++) emem[(off + i) & 4095] = src[i];
      end else if (md == 3) begin
        for (int y = 0; y < h; y++)
          for (int x = 0; x < w; x++)
            for (int dy = 0; dy < 2; dy++)
              for (int dx = 0; dx < 2; dx++)
                emem[(off + (2*y+dy)*tp + 2*x + dx) & 4095] = src[y*w + x];
      end else begin
        for (int y = 0; y < h; y++)
          for (int x = 0; x < sp; x++)
            emem[(off + y*tp + x) & 4095] = src[y*sp + x];
      end
      nbad = 0; first = 0;
      for (int i = 0; i < 4096; i++)
        if (bmem[i] !== emem[i]) begin
          if (nbad == 0) first = i;
          nbad++;
        end
      chk(nbad == 0, tag, $sformatf("memory image at word %0d", first), bmem[first], emem[first]);
      chk(sidx == stream_cnt(md, sp, w, h), "R11", {tag, " stream words consumed"},
          sidx, stream_cnt(md, sp, w, h));
    end else begin
      chk(ngot == exp_acc, "R11", {tag, " output word count"}, ngot, exp_acc);
      nbad = 0; first = 0; k = 0;
      for (int y = 0; y < h; y++)
        for (int x = 0; x < ((md == 3) ? w : sp); x++) begin
          int a;
          if (md == 0) a = off + y*sp + x;
          else if (md == 3) a = off + 2*y*tp + 2*x;
          else a = off + y*tp + x;
          if (k < ngot && k < 256 && got[k] !== bmem[a & 4095]) begin
            if (nbad == 0) first = k;
            nbad++;
          end
          k++;
        end
      chk(nbad == 0, tag, $sformatf("read stream order R11 word %0d", first), got[first & 255], 0);
    end
  endtask

  function automatic string tag_of(input bit rd, input int md);
    if (md == 3) return rd ? "R6" : "R5";
    if (rd) return "R7";
    if (md == 0) return "R2";
    if (md == 2) return "R4";
    return "R3";
  endfunction

  initial begin
    void'($urandom(32'h00c0ffee));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!busy && !done && !err && !mem_valid && !in_ready && !out_valid, "R1",
        "outputs idle after reset", {busy, done, err, mem_valid, in_ready, out_valid}, 0);

    // R3 and R4: plain and two-by-one give the same image
    fill(1); run(0, 1, 37, 9, 5, 3, 4, 0); verify(0, 1, 37, 9, 5, 3, 4, "R3");
    fill(1); run(0, 2, 37, 9, 5, 3, 4, 0); verify(0, 2, 37, 9, 5, 3, 4, "R4");
    fill(2); run(1, 2, 11, 7, 6, 2, 3, 0); verify(1, 2, 11, 7, 6, 2, 3, "R4");

    // R9 empty transfers
    fill(3); run(0, 3, 10, 8, 4, 3, 0, 0);
    chk(done_it == 1 && nacc == 0, "R9", "zero height", done_it * 100 + nacc, 100);
    fill(3); run(1, 3, 10, 8, 4, 0, 3, 0);
    chk(done_it == 1 && nacc == 0, "R9", "zero width quad", done_it * 100 + nacc, 100);
    fill(3); run(0, 1, 10, 8, 0, 5, 3, 0);
    chk(done_it == 1 && nacc == 0, "R9", "zero src pitch", done_it * 100 + nacc, 100);

    // R8 unsupported modes
    fill(4); run(0, 5, 10, 8, 4, 3, 3, 0);
    chk(err_it == 1 && nacc == 0 && done_it < 0, "R8", "mode 5", err_it * 100 + nacc, 100);
    fill(4); run(1, 7, 10, 8, 4, 3, 3, 0);
    chk(err_it == 1 && nacc == 0 && done_it < 0, "R8", "mode 7", err_it * 100 + nacc, 100);

    // R12 second start while busy
    fill(5); run(0, 1, 40, 10, 4, 2, 4, 1); verify(0, 1, 40, 10, 4, 2, 4, "R12");

    // R5 overlapping quads (pitch below twice width), R6 readback
    fill(6); run(0, 3, 50, 5, 4, 4, 3, 0); verify(0, 3, 50, 5, 4, 4, 3, "R5");
    fill(7); run(1, 3, 50, 12, 4, 4, 3, 0); verify(1, 3, 50, 12, 4, 4, 3, "R6");

    for (int t = 0; t < 40; t++) begin
      int md, off, tp, sp, w, h;
      bit rd;
      md = $urandom_range(0, 3); rd = 1'($urandom_range(0, 1));
      off = $urandom_range(0, 300); tp = $urandom_range(4, 24);
      sp = $urandom_range(1, 8); w = $urandom_range(1, 6); h = $urandom_range(1, 6);
      fill(t + 100);
      run(rd, md, off, tp, sp, w, h, 0);
      verify(rd, md, off, tp, sp, w, h, tag_of(rd, md));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule